// File: doc/BRIEF.md
# GPIO Function Select and Output Latch Core

This block is the register side of a general-purpose I/O controller with 54 pins. A simple 32-bit read/write bus reaches three register groups. The first holds a 3-bit function code for every pin. The second drives the output latches through separate set and clear words. The third returns the synchronized pin levels. Software turns individual outputs on or off by writing a one to a set bit or a clear bit. Bits written as zero leave their pins alone, so no read-modify-write sequence is needed.

For each pin the core exports its function code, an output enable and the latched output value. An external multiplexer combines these with the alternate peripherals and drives the pads. Pins are grouped in banks of 32 for set, clear and level access. Function codes are packed ten pins per word.

Top module: `gpio_fsel_core`

## Requirements
- R1: After synchronous reset every function code is 0, every output latch is 0, every output enable is 0, and `bus_rdata` is 0.
- R2: The function code of pin p is held in word p/10, at byte offset (p/10)*4 from 0x00, in bits [(p%10)*3 +: 3]. A write to that word updates the code, and a read of that word returns it.
- R3: Bits 30 and 31 of every function word read as zero. So do the fields of nonexistent pins 54..59 in word 5, and the bank-1 bits 22..31 of the level words. Writes to those positions change nothing.
- R4: A write to the set word of bank b (byte 0x1C for pins 0..31, byte 0x20 for pins 32..53) drives each pin whose data bit is 1 to a latched high. Data bits that are 0 leave their latches unchanged.
- R5: A write to the clear word of bank b (byte 0x28 for pins 0..31, byte 0x2C for pins 32..53) drives each pin whose data bit is 1 to a latched low. Data bits that are 0 leave their latches unchanged.
- R6: The level words (byte 0x34 for pins 0..31, byte 0x38 for pins 32..53) return the pin inputs after a two-flop synchronizer, whatever function each pin has selected. A level change at an input is first seen by a read strobe sampled at the third rising edge after the change. A strobe sampled at the second rising edge still returns the old level.
- R7: `pin_oe` of a pin is 1 exactly when its function code is 1 (output). Code 0 (input) and the alternate codes give 0. The alternate codes are: 4..7 select alternates 0..3, 3 selects alternate 4, and 2 selects alternate 5.
- R8: `pin_func[p*3 +: 3]` carries the stored function code of pin p in the cycle after the write.
- R9: Reads of the set and clear words return zero. So does a read of any word outside the function, set, clear and level words.
- R10: Read data is registered. It appears on `bus_rdata` in the cycle after the clock edge that samples `bus_rd`, and `bus_rdata` is 0 in any cycle that follows an edge with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte address; bits [7:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 54 | Asynchronous pin input levels |
| pin_func | output | 162 | Function code per pin, pin p at [p*3 +: 3] |
| pin_oe | output | 54 | Output enable per pin |
| pin_out | output | 54 | Output latch per pin |

## Verification
The function words are written with sparse codes at the field edges (pins 0, 3 and 9), with all ones, and with all ones into the partly filled last word. This separates a wrong field offset from a failure to mask the padding bits. Set and clear words are driven with single-bit, multi-bit and all-zero patterns on both banks. The zero patterns show that unselected latches hold their value. The all-ones pattern on bank 1 shows that bits past pin 53 are dropped. A mixed level pattern is read while some pins are outputs or alternates, and a second change is read at the second and then the third edge, which pins the synchronizer depth to exactly two flops.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Function codes; the alternate ordering is fixed by software
  typedef enum logic [2:0] {
    FN_IN   = 3'd0,
    FN_OUT  = 3'd1,
    FN_ALT5 = 3'd2,
    FN_ALT4 = 3'd3,
    FN_ALT0 = 3'd4,
    FN_ALT1 = 3'd5,
    FN_ALT2 = 3'd6,
    FN_ALT3 = 3'd7
  } fn_code_t;

  // Word indices (byte offset / 4) of the bank-0 word of each group
  localparam int SET_WORD = 7;
  localparam int CLR_WORD = 10;
  localparam int LEV_WORD = 13;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 54,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

  // R6: the last stage carries what the first stage held one cycle earlier
  a_r6_sync_shift: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (stg[STAGES-1] == $past(stg[STAGES-2])));
endmodule

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int FW       = 3,
  parameter int PPW      = 10,
  parameter int DW       = 32,
  parameter int IDX_W    = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DW-1:0]          wr_data,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [DW-1:0]          rd_data,
  output logic [NUM_PINS*FW-1:0] func,
  output logic [NUM_PINS-1:0]    oe
);
  logic [NUM_PINS*FW-1:0] func_q;
  logic [NUM_PINS-1:0]    oe_q;
  logic                   unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DW-1:PPW*FW];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WORD = p / PPW;
    localparam int SH   = (p % PPW) * FW;
    always_ff @(posedge clk) begin
      if (rst) begin
        func_q[p*FW +: FW] <= '0;
        oe_q[p]            <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(WORD)) begin
        func_q[p*FW +: FW] <= wr_data[SH +: FW];
        oe_q[p]            <= (wr_data[SH +: FW] == FN_OUT);
      end
    end

    // R7: the enable flag agrees with the stored code
    a_r7_oe_matches_code: assert property (@(posedge clk) disable iff (rst)
      oe_q[p] == (func_q[p*FW +: FW] == FN_OUT));
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (rd_idx == IDX_W'(p / PPW))
        rd_data[(p % PPW)*FW +: FW] = func_q[p*FW +: FW];
    end
  end

  assign func = func_q;
  assign oe   = oe_q;
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int NUM_PINS = 54
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] set_vec,
  input  logic [NUM_PINS-1:0] clr_vec,
  output logic [NUM_PINS-1:0] out
);
  logic [NUM_PINS-1:0] out_q;

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= (out_q | set_vec) & ~clr_vec;
  end

  assign out = out_q;

  a_r4_set_forces_high: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((out_q & $past(set_vec)) == $past(set_vec)));

  a_r5_clear_forces_low: assert property (@(posedge clk) disable iff (rst)
    (|clr_vec) |=> ((out_q & $past(clr_vec)) == '0));

  a_r4_untouched_bits_hold: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (((out_q ^ $past(out_q)) & ~$past(set_vec | clr_vec)) == '0));
endmodule

// File: rtl/gpio_fsel_core.sv
module gpio_fsel_core
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 54,
  parameter int ADDR_W      = 8,
  parameter int DW          = 32,
  parameter int FW          = 3,
  parameter int PPW         = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]    pin_in,
  output logic [NUM_PINS*FW-1:0] pin_func,
  output logic [NUM_PINS-1:0]    pin_oe,
  output logic [NUM_PINS-1:0]    pin_out
);
  localparam int IDX_W       = ADDR_W - 2;
  localparam int NUM_BANKS   = (NUM_PINS + DW - 1) / DW;
  localparam int PAD_W       = NUM_BANKS * DW;
  localparam int FSEL_WORDS  = (NUM_PINS + PPW - 1) / PPW;

  logic [IDX_W-1:0]    idx;
  logic [DW-1:0]       fsel_rword;
  logic [DW-1:0]       rd_word;
  logic [DW-1:0]       rdata_q;
  logic [NUM_PINS-1:0] lvl;
  logic [PAD_W-1:0]    lvl_pad;
  logic [PAD_W-1:0]    set_pad;
  logic [PAD_W-1:0]    clr_pad;
  logic                fsel_we;
  logic                unused_addr_lsb;
  logic                unused_pad_hi;

  assign idx             = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign fsel_we         = bus_wr && (idx < IDX_W'(FSEL_WORDS));

  gpio_fsel_regs #(
    .NUM_PINS(NUM_PINS), .FW(FW), .PPW(PPW), .DW(DW), .IDX_W(IDX_W)
  ) u_fsel (
    .clk(clk), .rst(rst),
    .wr_en(fsel_we), .wr_idx(idx), .wr_data(bus_wdata),
    .rd_idx(idx), .rd_data(fsel_rword),
    .func(pin_func), .oe(pin_oe)
  );

  always_comb begin
    set_pad = '0;
    clr_pad = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_wr && idx == IDX_W'(SET_WORD + b)) set_pad[b*DW +: DW] = bus_wdata;
      if (bus_wr && idx == IDX_W'(CLR_WORD + b)) clr_pad[b*DW +: DW] = bus_wdata;
    end
  end

  assign unused_pad_hi = ^{set_pad[PAD_W-1:NUM_PINS], clr_pad[PAD_W-1:NUM_PINS]};

  gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk(clk), .rst(rst),
    .set_vec(set_pad[NUM_PINS-1:0]),
    .clr_vec(clr_pad[NUM_PINS-1:0]),
    .out(pin_out)
  );

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl)
  );

  assign lvl_pad = PAD_W'(lvl);

  always_comb begin
    rd_word = '0;
    if (idx < IDX_W'(FSEL_WORDS)) rd_word = fsel_rword;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (idx == IDX_W'(LEV_WORD + b)) rd_word = lvl_pad[b*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_word;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;

  a_r10_idle_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  a_r9_setclr_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (idx == IDX_W'(SET_WORD) || idx == IDX_W'(CLR_WORD) ||
                idx == IDX_W'(SET_WORD + 1) || idx == IDX_W'(CLR_WORD + 1)))
      |=> (bus_rdata == '0));

  a_r3_fsel_top_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && idx < IDX_W'(FSEL_WORDS)) |=> (bus_rdata[DW-1:PPW*FW] == '0));
endmodule

// File: tb/sim_gpio_fsel_core.sv
module sim_gpio_fsel_core;
  localparam int NP = 54;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP*3-1:0] pin_func;
  logic [NP-1:0] pin_oe;
  logic [NP-1:0] pin_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [2:0]    m_code [NP];
  logic [NP-1:0] m_out = '0;

  always #10 clk = ~clk;

  gpio_fsel_core u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_func(pin_func), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a < 8'h18) begin
      for (int k = 0; k < 10; k++) begin
        int p = (a >> 2) * 10 + k;
        if (p < NP) m_code[p] = d[k*3 +: 3];
      end
    end
    if (a == 8'h1C) m_out[31:0]  = m_out[31:0] | d;
    if (a == 8'h20) m_out[53:32] = m_out[53:32] | d[21:0];
    if (a == 8'h28) m_out[31:0]  = m_out[31:0] & ~d;
    if (a == 8'h2C) m_out[53:32] = m_out[53:32] & ~d[21:0];
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check_pins(input string req);
    logic [NP-1:0] exp_oe;
    bit func_ok = 1'b1;
    for (int p = 0; p < NP; p++) begin
      exp_oe[p] = (m_code[p] == 3'd1);
      if (pin_func[p*3 +: 3] !== m_code[p]) func_ok = 1'b0;
    end
    check(func_ok, {req, " R8 pin_func"}, 64'(pin_func[63:0]), 64'(0));
    check(pin_oe === exp_oe, {req, " R7 pin_oe"}, 64'(pin_oe), 64'(exp_oe));
    check(pin_out === m_out, {req, " out latch"}, 64'(pin_out), 64'(m_out));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int p = 0; p < NP; p++) m_code[p] = 3'd0;
    check(bus_rdata === 32'h0, "R1 rdata after reset", 64'(bus_rdata), 0);
    check_pins("R1");
    rd(8'h00, d);
    check(d === 32'h0, "R1 fsel word0 after reset", 64'(d), 0);
  endtask

  task automatic t_fsel;
    logic [31:0] d;
    wr(8'h00, 32'h1 | (32'h4 << 9) | (32'h7 << 27));
    check_pins("R2 word0");
    rd(8'h00, d);
    check(d === (32'h1 | (32'h4 << 9) | (32'h7 << 27)), "R2 word0 readback", 64'(d), 64'(32'h1 | (32'h4 << 9) | (32'h7 << 27)));
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d);
    check(d === 32'h3FFF_FFFF, "R3 word1 bits 30-31 zero", 64'(d), 64'h3FFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d);
    check(d === 32'h0000_0FFF, "R3 word5 pins 54-59 zero", 64'(d), 64'h0FFF);
    wr(8'h14, 32'h3 << 9);
    check(pin_func[53*3 +: 3] === 3'd3, "R8 pin53 code alt4", 64'(pin_func[53*3 +: 3]), 3);
    check_pins("R2 word5");
  endtask

  task automatic t_oe;
    wr(8'h08, 32'h1 | (32'h4 << 3) | (32'h2 << 6) | (32'h3 << 9) | (32'h7 << 15));
    check(pin_oe[24:20] === 5'b00001, "R7 oe only on code 1", 64'(pin_oe[24:20]), 64'b00001);
    check_pins("R7 mixed codes");
  endtask

  task automatic t_set;
    wr(8'h1C, 32'h8000_0005);
    check(pin_out === m_out, "R4 set bank0 bits", 64'(pin_out), 64'(m_out));
    wr(8'h1C, 32'h0);
    check(pin_out === m_out, "R4 zero set no effect", 64'(pin_out), 64'(m_out));
    wr(8'h20, 32'hFFFF_FFFF);
    check(pin_out === m_out, "R4 set bank1 all ones", 64'(pin_out), 64'(m_out));
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(8'h28, 32'h0000_0004);
    check(pin_out === m_out, "R5 clear pin2", 64'(pin_out), 64'(m_out));
    wr(8'h2C, 32'h0);
    check(pin_out === m_out, "R5 zero clear no effect", 64'(pin_out), 64'(m_out));
    wr(8'h2C, 32'h0020_0001);
    check(pin_out === m_out, "R5 clear pins 32 and 53", 64'(pin_out), 64'(m_out));
    rd(8'h1C, d);
    check(d === 32'h0, "R9 set word reads zero", 64'(d), 0);
    rd(8'h2C, d);
    check(d === 32'h0, "R9 clear word reads zero", 64'(d), 0);
    rd(8'h18, d);
    check(d === 32'h0, "R9 unmapped 0x18 reads zero", 64'(d), 0);
    rd(8'h3C, d);
    check(d === 32'h0, "R9 unmapped 0x3C reads zero", 64'(d), 0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    logic [NP-1:0] a = 54'h2A_5A5A_C3C3_0F0F;
    pin_in = a;
    @(negedge clk); @(negedge clk);
    rd(8'h34, d);
    check(d === a[31:0], "R6 level bank0", 64'(d), 64'(a[31:0]));
    rd(8'h38, d);
    check(d === {10'b0, a[53:32]}, "R6 R3 level bank1", 64'(d), 64'({10'b0, a[53:32]}));
    pin_in = ~a;
    @(negedge clk);
    rd(8'h34, d);
    check(d === a[31:0], "R6 second edge still old", 64'(d), 64'(a[31:0]));
    rd(8'h34, d);
    check(d === ~a[31:0], "R6 third edge new level", 64'(d), 64'(~a[31:0]));
    @(negedge clk);
    check(bus_rdata === 32'h0, "R10 rdata zero without strobe", 64'(bus_rdata), 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fsel();
    t_oe();
    t_set();
    t_clear();
    t_level();
    check_pins("final");
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'(0), 64'(1));
      finish_run();
    end
  end
endmodule